// File: doc/BRIEF.md
# LPC Host SYNC Phase Monitor

This block sits on the host side of a Low Pin Count bus and judges the SYNC phase of each cycle. The host pulses `start_i` when it turns the bus over to the target. From the next clock onward the monitor samples one nibble of `lad_i` per clock and decides how the SYNC phase ends. It can end in one of three ways: the cycle completes, the target reports an error, or the host must abort. Every outcome is a single-clock pulse. After the pulse the monitor goes idle and ignores the bus until the next start.

Two separate guards decide an abort. The first counts an unbroken run of clocks that carry no recognised SYNC code. The second counts how many short-wait codes a cycle has used. Long-wait codes reset the first guard and have no limit of their own. A target that switches between the two wait codes within one cycle is also aborted. An error outcome carries two flags. One says whether data nibbles still follow, which is the case on a read. The other tells a multi-byte transfer engine to drop the bytes that remain.

The abort sequence on the frame signal and the capture of data nibbles belong to other blocks.

Top module: `lpc_sync_monitor`

## Requirements
- R1: After reset all outputs are low and the monitor is idle. A `start_i` pulse while idle arms it, and the first nibble is sampled on the following clock. A `start_i` that arrives while the monitor is armed, including in the clock that carries the ending nibble, is ignored.
- R2: A nibble of 4'b0000 or 4'b1001 ends the phase. In the clock after that nibble, `done_o` and `data_follows_o` are both high.
- R3: A nibble of 4'b1010 ends the phase. In the clock after it, `error_o` is high, and `data_follows_o` equals the `is_read_i` value captured at start.
- R4: `burst_stop_o` pulses together with `error_o` when `multi_byte_i` was high at start. It stays low with every other outcome.
- R5: An invalid nibble is any value other than 0000, 0101, 0110, 1001 and 1010. Three invalid nibbles in a row pulse `abort_o` in the clock after the third one. Any valid nibble restarts this run from zero.
- R6: The short-wait code 4'b0101 may appear at most 8 times in one cycle, and the 9th occurrence pulses `abort_o`. Invalid nibbles in between do not reset this tally.
- R7: The long-wait code 4'b0110 may repeat any number of times without causing an abort.
- R8: A long-wait code after a short-wait code in the same cycle pulses `abort_o`, and so does a short-wait code after a long-wait code.
- R9: At most one of `done_o`, `error_o` and `abort_o` is high in any clock, and each is high for one clock only. Nibbles sampled after an outcome and before the next start produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Bus handed to target; arms the monitor when idle |
| is_read_i | input | 1 | Cycle is a read; captured at start |
| multi_byte_i | input | 1 | Cycle is a multi-byte transfer; captured at start |
| lad_i | input | 4 | Bus nibble sampled each clock |
| done_o | output | 1 | Pulse: phase completed |
| error_o | output | 1 | Pulse: target signalled an error |
| abort_o | output | 1 | Pulse: host must abort the cycle |
| data_follows_o | output | 1 | High with an outcome pulse when data nibbles follow |
| burst_stop_o | output | 1 | Pulse with an error: drop the remaining bytes of a multi-byte transfer |

## Verification
Two functions can fall in the same clock. One is the arrival of the nibble that ends the phase. The other is a fresh start request, which the idle logic would otherwise accept. The bench raises `start_i` in exactly the clock that carries the ending nibble, and also in a mid-phase wait clock. It judges the result by checking that a single outcome pulse appears at the predicted clock. It also checks that the ready nibbles driven afterwards produce no second pulse, which shows the start request lost.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;

   localparam logic [3:0] CODE_READY     = 4'b0000;
   localparam logic [3:0] CODE_READY_ALT = 4'b1001;
   localparam logic [3:0] CODE_SHORT     = 4'b0101;
   localparam logic [3:0] CODE_LONG      = 4'b0110;
   localparam logic [3:0] CODE_ERROR     = 4'b1010;

   typedef enum logic [2:0] {
      CLS_INVALID,
      CLS_READY,
      CLS_SHORT,
      CLS_LONG,
      CLS_ERROR
   } sync_cls_e;

   typedef enum logic [1:0] {
      WAIT_NONE,
      WAIT_SHORT,
      WAIT_LONG
   } wait_mode_e;

   typedef enum logic [1:0] {
      OUT_NONE,
      OUT_DONE,
      OUT_ERROR,
      OUT_ABORT
   } outcome_e;

endpackage

// File: rtl/lpc_sync_decode.sv
module lpc_sync_decode
   import lpc_sync_pkg::*;
(
   input  logic [3:0] nib_i,
   output sync_cls_e  cls_o
);

   always_comb begin
      case (nib_i)
         CODE_READY, CODE_READY_ALT: cls_o = CLS_READY;
         CODE_SHORT:                 cls_o = CLS_SHORT;
         CODE_LONG:                  cls_o = CLS_LONG;
         CODE_ERROR:                 cls_o = CLS_ERROR;
         default:                    cls_o = CLS_INVALID;
      endcase
   end

endmodule

// File: rtl/lpc_limit_counter.sv
module lpc_limit_counter #(
   parameter int unsigned LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic hit_o
);

   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("lpc_limit_counter: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign hit_o = inc_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i || hit_o) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R5, R6: the tally never passes the last allowed value
   assert_cnt_in_range_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R5, R6: a clear always wins over an increment
   assert_clear_wins_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/lpc_wait_tracker.sv
module lpc_wait_tracker
   import lpc_sync_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic see_short_i,
   input  logic see_long_i,
   output logic conflict_o
);

   wait_mode_e mode_q;

   assign conflict_o = ((mode_q == WAIT_SHORT) && see_long_i) ||
                       ((mode_q == WAIT_LONG)  && see_short_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= WAIT_NONE;
      end else if (clr_i) begin
         mode_q <= WAIT_NONE;
      end else if (mode_q == WAIT_NONE) begin
         if (see_short_i) begin
            mode_q <= WAIT_SHORT;
         end else if (see_long_i) begin
            mode_q <= WAIT_LONG;
         end
      end
   end

   // R8: once a wait style is chosen it stays until the cycle is cleared
   assert_mode_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q != WAIT_NONE) && !clr_i) |=> (mode_q == $past(mode_q)));

   // R8: a conflict needs an earlier, different wait code
   assert_conflict_needs_mode_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      conflict_o |-> (mode_q != WAIT_NONE));

endmodule

// File: rtl/lpc_sync_monitor.sv
module lpc_sync_monitor
   import lpc_sync_pkg::*;
#(
   parameter int unsigned INV_LIMIT   = 3,
   parameter int unsigned SHORT_LIMIT = 8,
   parameter int unsigned LONG_LIMIT  = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       is_read_i,
   input  logic       multi_byte_i,
   input  logic [3:0] lad_i,
   output logic       done_o,
   output logic       error_o,
   output logic       abort_o,
   output logic       data_follows_o,
   output logic       burst_stop_o
);

   localparam int unsigned SHORT_TRIP = SHORT_LIMIT + 1;
   localparam int unsigned LONG_TRIP  = LONG_LIMIT + 1;

   if (INV_LIMIT < 1) begin : g_bad_inv
      $error("lpc_sync_monitor: INV_LIMIT must be at least 1");
   end

   logic      busy_q;
   logic      rd_q;
   logic      multi_q;
   sync_cls_e cls;
   outcome_e  outcome;
   logic      inv_hit;
   logic      short_hit;
   logic      long_hit;
   logic      conflict;
   logic      see_inv;
   logic      see_short;
   logic      see_long;

   lpc_sync_decode u_decode (
      .nib_i (lad_i),
      .cls_o (cls)
   );

   assign see_inv   = busy_q && (cls == CLS_INVALID);
   assign see_short = busy_q && (cls == CLS_SHORT);
   assign see_long  = busy_q && (cls == CLS_LONG);

   lpc_limit_counter #(.LIMIT(INV_LIMIT)) u_inv_run (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (!busy_q || (cls != CLS_INVALID)),
      .inc_i (see_inv),
      .hit_o (inv_hit)
   );

   lpc_limit_counter #(.LIMIT(SHORT_TRIP)) u_short_tally (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (!busy_q),
      .inc_i (see_short),
      .hit_o (short_hit)
   );

   if (LONG_LIMIT == 0) begin : g_long_free
      assign long_hit = 1'b0;
   end else begin : g_long_capped
      lpc_limit_counter #(.LIMIT(LONG_TRIP)) u_long_tally (
         .clk   (clk),
         .rst_n (rst_n),
         .clr_i (!busy_q),
         .inc_i (see_long),
         .hit_o (long_hit)
      );
   end

   lpc_wait_tracker u_wait (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (!busy_q),
      .see_short_i (see_short),
      .see_long_i  (see_long),
      .conflict_o  (conflict)
   );

   always_comb begin
      outcome = OUT_NONE;
      if (busy_q) begin
         case (cls)
            CLS_READY:   outcome = OUT_DONE;
            CLS_ERROR:   outcome = OUT_ERROR;
            CLS_INVALID: if (inv_hit) outcome = OUT_ABORT;
            CLS_SHORT:   if (short_hit || conflict) outcome = OUT_ABORT;
            CLS_LONG:    if (long_hit || conflict) outcome = OUT_ABORT;
            default:     outcome = OUT_NONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q         <= 1'b0;
         rd_q           <= 1'b0;
         multi_q        <= 1'b0;
         done_o         <= 1'b0;
         error_o        <= 1'b0;
         abort_o        <= 1'b0;
         data_follows_o <= 1'b0;
         burst_stop_o   <= 1'b0;
      end else begin
         done_o         <= (outcome == OUT_DONE);
         error_o        <= (outcome == OUT_ERROR);
         abort_o        <= (outcome == OUT_ABORT);
         data_follows_o <= (outcome == OUT_DONE) || ((outcome == OUT_ERROR) && rd_q);
         burst_stop_o   <= (outcome == OUT_ERROR) && multi_q;
         if (busy_q) begin
            busy_q <= (outcome == OUT_NONE);
         end else if (start_i) begin
            busy_q  <= 1'b1;
            rd_q    <= is_read_i;
            multi_q <= multi_byte_i;
         end
      end
   end

   // R9: outcomes are mutually exclusive
   assert_one_outcome_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, error_o, abort_o}));

   // R9: an outcome is followed by a quiet clock
   assert_single_pulse_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || error_o || abort_o) |=> !(done_o || error_o || abort_o));

   // R1: arming from idle gives no outcome in the next clock
   assert_arm_quiet_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_q) |=> !(done_o || error_o || abort_o));

   // R2: a completion always announces data
   assert_done_has_data_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> data_follows_o);

   // R3: the data flag only rides on completion or error
   assert_data_flag_scope_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      data_follows_o |-> (done_o || error_o));

   // R4: remaining bytes are dropped only on an error
   assert_burst_on_error_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      burst_stop_o |-> error_o);

   // R7: long waits never end the phase by themselves
   assert_long_free_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (see_long && !conflict && (LONG_LIMIT == 0)) |=> !abort_o);

endmodule

// File: tb/tb_lpc_sync_monitor.sv
module tb_lpc_sync_monitor;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       is_read_i = 1'b0;
   logic       multi_byte_i = 1'b0;
   logic [3:0] lad_i = 4'h0;
   logic       done_o, error_o, abort_o, data_follows_o, burst_stop_o;

   int   tests = 0;
   int   fails = 0;
   longint cyc = 0;

   typedef struct {
      int     kind;   // 1 done, 2 error, 3 abort
      bit     df;
      bit     bs;
      longint when;
      string  tag;
   } exp_t;

   exp_t       exp_q[$];
   logic [3:0] seq[$];

   lpc_sync_monitor dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .is_read_i      (is_read_i),
      .multi_byte_i   (multi_byte_i),
      .lad_i          (lad_i),
      .done_o         (done_o),
      .error_o        (error_o),
      .abort_o        (abort_o),
      .data_follows_o (data_follows_o),
      .burst_stop_o   (burst_stop_o)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected outcomes as pulses appear
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (done_o || error_o || abort_o || data_follows_o || burst_stop_o) begin
            int k;
            k = done_o ? 1 : (error_o ? 2 : (abort_o ? 3 : 0));
            tests++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL unexpected output: kind=%0d df=%0b bs=%0b expected none (R9/R1)",
                        k, data_follows_o, burst_stop_o);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               if (k != e.kind || data_follows_o != e.df || burst_stop_o != e.bs ||
                   cyc != e.when || (done_o + error_o + abort_o) != 1) begin
                  fails++;
                  $display("FAIL %s: kind=%0d df=%0b bs=%0b cyc=%0d expected kind=%0d df=%0b bs=%0b cyc=%0d",
                           e.tag, k, data_follows_o, burst_stop_o, cyc,
                           e.kind, e.df, e.bs, e.when);
               end
            end
         end
      end
   end

   task automatic add(input logic [3:0] nib, input int n);
      for (int i = 0; i < n; i++) seq.push_back(nib);
   endtask

   // driver: runs one SYNC phase from seq and pushes its expected outcome
   task automatic run_seq(input bit rd, input bit mb, input int kind, input bit df,
                          input bit bs, input int busy_start_idx, input string tag);
      exp_t e;
      @(negedge clk);
      start_i = 1'b1;
      is_read_i = rd;
      multi_byte_i = mb;
      lad_i = 4'hF;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < seq.size(); i++) begin
         lad_i = seq[i];
         start_i = (i == busy_start_idx);
         if (i == seq.size() - 1) begin
            e.kind = kind; e.df = df; e.bs = bs; e.when = cyc + 1; e.tag = tag;
            exp_q.push_back(e);
         end
         @(negedge clk);
      end
      start_i = 1'b0;
      // idle nibbles, ready and invalid, must be ignored (R9)
      lad_i = 4'h0;
      repeat (2) @(negedge clk);
      lad_i = 4'hF;
      repeat (4) @(negedge clk);
      lad_i = 4'h0;
      tests++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL %s: outcome missing, pending=%0d expected 0", tag, exp_q.size());
         exp_q.delete();
      end
      seq.delete();
   endtask

   initial begin
      #(200000 * 8);
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tests++;
      if ({done_o, error_o, abort_o, data_follows_o, burst_stop_o} != 5'b0) begin
         fails++;
         $display("FAIL R1 reset: outputs=%b expected 00000",
                  {done_o, error_o, abort_o, data_follows_o, burst_stop_o});
      end

      add(4'h0, 1);                                run_seq(1, 0, 1, 1, 0, -1, "R2 ready 0000");
      add(4'h5, 2); add(4'h9, 1);                  run_seq(0, 0, 1, 1, 0, -1, "R2 ready 1001 after short waits");
      add(4'h6, 2); add(4'hA, 1);                  run_seq(1, 0, 2, 1, 0, -1, "R3 error on read");
      add(4'hA, 1);                                run_seq(0, 0, 2, 0, 0, -1, "R3 error on write");
      add(4'h5, 1); add(4'hA, 1);                  run_seq(1, 1, 2, 1, 1, -1, "R4 error multi-byte read");
      add(4'hA, 1);                                run_seq(0, 1, 2, 0, 1, -1, "R4 error multi-byte write");
      add(4'h0, 1);                                run_seq(1, 1, 1, 1, 0, -1, "R4 done multi-byte no stop");
      add(4'hF, 3);                                run_seq(1, 0, 3, 0, 0, -1, "R5 three invalid");
      add(4'h3, 2); add(4'h6, 1); add(4'hC, 2); add(4'h0, 1);
                                                   run_seq(1, 0, 1, 1, 0, -1, "R5 valid restarts run");
      add(4'h5, 8); add(4'h0, 1);                  run_seq(1, 0, 1, 1, 0, -1, "R6 eight short waits allowed");
      add(4'h5, 9);                                run_seq(1, 0, 3, 0, 0, -1, "R6 ninth short wait aborts");
      add(4'h5, 4); add(4'hF, 1); add(4'h5, 5);    run_seq(0, 0, 3, 0, 0, -1, "R6 tally kept over invalid");
      add(4'h6, 40); add(4'h9, 1);                 run_seq(1, 0, 1, 1, 0, -1, "R7 long waits unlimited");
      add(4'h5, 1); add(4'h6, 1);                  run_seq(1, 0, 3, 0, 0, -1, "R8 short then long");
      add(4'h6, 3); add(4'h5, 1);                  run_seq(0, 0, 3, 0, 0, -1, "R8 long then short");
      add(4'h6, 3); add(4'h0, 1);                  run_seq(1, 0, 1, 1, 0, 1,  "R1 start mid-phase ignored");
      add(4'h5, 1); add(4'h9, 1);                  run_seq(1, 0, 1, 1, 0, 1,  "R1 start with ending nibble ignored");

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule